// File: doc/BRIEF.md
# Synchronous SRAM Read Data Path

This block is the read-data return path of a synchronous burst SRAM. A small internal word array is addressed through an address register. The addressed word reaches the data outputs by one of two routes. In two-stage mode it passes through an extra output register. In single-stage mode it flows straight from the array behind the address register, so data arrives one cycle sooner. A static mode input picks the route.

Each clock edge decodes one cycle:
- A load with the chip selected opens a new access. It is a write if any byte enable is low, and a read otherwise.
- A load with the chip not selected closes access. This is a deselect.
- A clock with no load continues the current access at the held address. A read is suspended; a write goes to the same word again.

Tri-state pins are modelled as a data bus plus a drive-enable output. The drive enable is gated by three things: an asynchronous active-low output enable, the selected state, and the write state.

Top module: `sram_rd_path`

## Requirements
- R1: While reset is asserted and right after it, `dq_oe_o` is low.
- R2: With `flow_sel_n` HIGH (two-stage mode), a read whose address is loaded on clock edge k presents that word on `dq_o`, with `dq_oe_o` high, after edge k+1.
- R3: With `flow_sel_n` LOW (single-stage mode), a read loaded on edge k presents its word after edge k itself, one cycle earlier than in R2.
- R4: `oe_n_i` acts without a clock: while it is HIGH, `dq_oe_o` is low. When it falls, the drive enable returns at once to the value the cycle state gives.
- R5: A cycle whose byte enables `be_n_i` (active low) include at least one low bit is a write. After its edge `dq_oe_o` is low, whatever the level of `oe_n_i`.
- R6: After a load with `sel_i` low (deselect), `dq_oe_o` is low:
  - after the next edge in single-stage mode;
  - after the second edge in two-stage mode, since the word already in flight is still delivered after the first edge.
- R7: A suspended read holds its address and keeps presenting the same word. A suspended read is a clock with `ld_i` low, no byte enable low, and no prior write.
- R8: A write updates only the byte lanes whose enable is low. Lane g is bits [g*LANE +: LANE], where LANE = WIDTH/BYTES, and is controlled by `be_n_i[g]`.
- R9: A read of an address written in the immediately preceding cycle returns the newly written data.
- R10: Byte enables that are low while no access is open (after a deselect, with `ld_i` low) change no array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_sel_n | input | 1 | Static mode select: LOW single-stage, HIGH two-stage |
| ld_i | input | 1 | Load strobe: start a new cycle at `addr_i` |
| sel_i | input | 1 | Chip selected, sampled with `ld_i` |
| addr_i | input | ADDR_W | Word address, taken on a load |
| be_n_i | input | BYTES | Active-low byte write enables |
| wdata_i | input | WIDTH | Write data |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| dq_o | output | WIDTH | Read data bus |
| dq_oe_o | output | 1 | Drive enable standing in for the tri-state pins |

## Verification
The bench runs the same directed and random traffic in both modes, against a behavioural model that tracks open, suspended and closed accesses. This separates the two latencies (R2, R3): a one-cycle skew fails every compare. It also separates the deselect timing of the two modes (R6).

The remaining patterns each target one rule:
- A write followed at once by a read of the same word tells capture-after-write from a stale read.
- A single-lane write tells per-lane masking from whole-word writes.
- Low enables while no access is open expose any array update that leaks through.
- Mid-cycle toggles of the output enable show that gating needs no clock edge.

// File: rtl/srd_pkg.sv
package srd_pkg;

    // Cycle kind decoded on each clock edge
    typedef enum logic [1:0] {
        CYC_HOLD = 2'd0,   // no load: continue or suspend current access
        CYC_OPEN = 2'd1,   // load with chip selected: new access
        CYC_DROP = 2'd2    // load with chip not selected: deselect
    } cyc_e;

    function automatic cyc_e cyc_decode(input logic ld, input logic sel);
        if (!ld)     return CYC_HOLD;
        else if (sel) return CYC_OPEN;
        else          return CYC_DROP;
    endfunction

endpackage

// File: rtl/srd_access.sv
module srd_access
    import srd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTES-1:0]  be_n_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rdok_o,
    output logic              wr_o,
    output logic [BYTES-1:0]  wr_lane_o,
    output logic [ADDR_W-1:0] wr_addr_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              act;
        logic              wr;
    } acc_t;

    acc_t acc_d, acc_q;
    cyc_e cyc;
    logic any_wr;

    always_comb begin
        cyc       = cyc_decode(ld_i, sel_i);
        any_wr    = |(~be_n_i);
        acc_d     = acc_q;
        wr_lane_o = '0;
        wr_addr_o = acc_q.addr;
        unique case (cyc)
            CYC_OPEN: begin
                acc_d.addr = addr_i;
                acc_d.act  = 1'b1;
                acc_d.wr   = any_wr;
                wr_lane_o  = ~be_n_i;
                wr_addr_o  = addr_i;
            end
            CYC_DROP: begin
                acc_d.act = 1'b0;
                acc_d.wr  = 1'b0;
            end
            default: begin
                acc_d.wr  = acc_q.act & any_wr;
                wr_lane_o = acc_q.act ? ~be_n_i : '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign addr_o = acc_q.addr;
    assign rdok_o = acc_q.act & ~acc_q.wr;
    assign wr_o   = acc_q.wr;

endmodule

// File: rtl/srd_array.sv
module srd_array #(
    parameter int ADDR_W = 8,
    parameter int WIDTH  = 18,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic [BYTES-1:0]  wr_lane_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WIDTH-1:0]  rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANE  = WIDTH / BYTES;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] mask;

    // Expand the per-lane write enables into a bit mask
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign mask[g*LANE +: LANE] = {LANE{wr_lane_i[g]}};
    end

    always_ff @(posedge clk) begin
        if (|wr_lane_i)
            mem[wr_addr_i] <= (mem[wr_addr_i] & ~mask) | (wdata_i & mask);
    end

    assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/srd_outstage.sv
module srd_outstage #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flow_sel_n,
    input  logic [WIDTH-1:0] rd_data_i,
    input  logic             rdok_i,
    input  logic             wr_i,
    input  logic             oe_n_i,
    output logic [WIDTH-1:0] dq_o,
    output logic             dq_oe_o
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             ok;
    } stg_t;

    stg_t stg_d, stg_q;
    logic ok_sel;

    always_comb begin
        stg_d.data = rd_data_i;
        stg_d.ok   = rdok_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    always_comb begin
        dq_o    = flow_sel_n ? stg_q.data : rd_data_i;
        ok_sel  = flow_sel_n ? stg_q.ok   : rdok_i;
        dq_oe_o = ~oe_n_i & ok_sel & ~wr_i;
    end

endmodule

// File: rtl/sram_rd_path.sv
module sram_rd_path #(
    parameter int ADDR_W = 8,
    parameter int WIDTH  = 18,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_sel_n,
    input  logic              ld_i,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTES-1:0]  be_n_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic              oe_n_i,
    output logic [WIDTH-1:0]  dq_o,
    output logic              dq_oe_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTES-1:0]  wr_lane;
    logic              rdok;
    logic              wr_q;
    logic [WIDTH-1:0]  rd_data;

    srd_access #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (ld_i),
        .sel_i     (sel_i),
        .addr_i    (addr_i),
        .be_n_i    (be_n_i),
        .addr_o    (addr_q),
        .rdok_o    (rdok),
        .wr_o      (wr_q),
        .wr_lane_o (wr_lane),
        .wr_addr_o (wr_addr)
    );

    srd_array #(.ADDR_W(ADDR_W), .WIDTH(WIDTH), .BYTES(BYTES)) u_array (
        .clk       (clk),
        .wr_lane_i (wr_lane),
        .wr_addr_i (wr_addr),
        .wdata_i   (wdata_i),
        .rd_addr_i (addr_q),
        .rd_data_o (rd_data)
    );

    srd_outstage #(.WIDTH(WIDTH)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .flow_sel_n (flow_sel_n),
        .rd_data_i  (rd_data),
        .rdok_i     (rdok),
        .wr_i       (wr_q),
        .oe_n_i     (oe_n_i),
        .dq_o       (dq_o),
        .dq_oe_o    (dq_oe_o)
    );

endmodule

// File: rtl/srd_chk.sv
module srd_chk #(
    parameter int ADDR_W = 8,
    parameter int WIDTH  = 18,
    parameter int BYTES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flow_sel_n,
    input logic              ld_i,
    input logic              sel_i,
    input logic [BYTES-1:0]  be_n_i,
    input logic              oe_n_i,
    input logic [WIDTH-1:0]  dq_o,
    input logic              dq_oe_o
);

    // R1
    rst_idle_chk: assert property (@(posedge clk) !rst_n |-> !dq_oe_o);

    // R4
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !dq_oe_o);

    // R5
    write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && sel_i && !(&be_n_i)) |=> !dq_oe_o);

    // R6
    drop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_sel_n && ld_i && !sel_i) |=> !dq_oe_o);

    // R6
    drop_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_sel_n && ld_i && !sel_i) |-> ##2 !dq_oe_o);

    // R7
    hold_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_sel_n && !ld_i && (&be_n_i)) |=> $stable(dq_o));

    // R7
    hold_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_sel_n && !ld_i && (&be_n_i) && $past(!ld_i && (&be_n_i)))
        |=> $stable(dq_o));

endmodule

bind sram_rd_path srd_chk #(.ADDR_W(ADDR_W), .WIDTH(WIDTH), .BYTES(BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flow_sel_n (flow_sel_n),
    .ld_i       (ld_i),
    .sel_i      (sel_i),
    .be_n_i     (be_n_i),
    .oe_n_i     (oe_n_i),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o)
);

// File: tb/tb_sram_rd_path.sv
module tb_sram_rd_path;

    localparam int PERIOD = 10;
    localparam int AW     = 8;
    localparam int W      = 18;
    localparam int NB     = 2;
    localparam int LANE   = W / NB;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          flow_sel_n;
    logic          ld_i, sel_i, oe_n_i;
    logic [AW-1:0] addr_i;
    logic [NB-1:0] be_n_i;
    logic [W-1:0]  wdata_i;
    logic [W-1:0]  dq_o;
    logic          dq_oe_o;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [W-1:0] mm [256];
    int           ma;
    bit           mact, mwr, mok1, pok, flow;
    logic [W-1:0] pdat;

    always #(PERIOD/2) clk = ~clk;

    sram_rd_path #(.ADDR_W(AW), .WIDTH(W), .BYTES(NB)) dut (
        .clk(clk), .rst_n(rst_n), .flow_sel_n(flow_sel_n), .ld_i(ld_i),
        .sel_i(sel_i), .addr_i(addr_i), .be_n_i(be_n_i), .wdata_i(wdata_i),
        .oe_n_i(oe_n_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s drive enable act=%b exp=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_dat(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s data act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_oe();
        return !oe_n_i && (flow ? mok1 : pok) && !mwr;
    endfunction

    function automatic logic [W-1:0] exp_dq();
        return flow ? mm[ma] : pdat;
    endfunction

    task automatic compare(input string tag);
        bit e;
        e = exp_oe();
        chk_bit(dq_oe_o, e, tag);
        if (e) chk_dat(dq_o, exp_dq(), tag);
    endtask

    task automatic model_edge();
        logic [W-1:0] pd;
        bit pk, anyw;
        int ea;
        pd   = mm[ma];
        pk   = mok1;
        anyw = (be_n_i != '1);
        if (((ld_i && sel_i) || (!ld_i && mact)) && anyw) begin
            ea = ld_i ? int'(addr_i) : ma;
            for (int g = 0; g < NB; g++)
                if (!be_n_i[g]) mm[ea][g*LANE +: LANE] = wdata_i[g*LANE +: LANE];
        end
        if (ld_i && sel_i) begin
            ma = int'(addr_i); mact = 1; mwr = anyw;
        end else if (ld_i) begin
            mact = 0; mwr = 0;
        end else begin
            mwr = mact && anyw;
        end
        mok1 = mact && !mwr;
        pdat = pd;
        pok  = pk;
    endtask

    task automatic step(input bit ld, input bit sel, input int a, input logic [NB-1:0] be,
                        input logic [W-1:0] wd, input bit oen, input string tag);
        ld_i = ld; sel_i = sel; addr_i = AW'(a); be_n_i = be; wdata_i = wd; oe_n_i = oen;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input bit fl);
        @(negedge clk);
        rst_n = 1'b0; ld_i = 0; sel_i = 0; addr_i = '0; be_n_i = '1; wdata_i = '0; oe_n_i = 0;
        flow = fl; flow_sel_n = !fl;
        ma = 0; mact = 0; mwr = 0; mok1 = 0; pok = 0; pdat = '0;
        repeat (2) @(negedge clk);
        chk_bit(dq_oe_o, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit(dq_oe_o, 1'b0, "R1");
    endtask

    task automatic run_mode(input bit fl, input bit prewrite);
        string lat;
        lat = fl ? "R3" : "R2";
        do_reset(fl);
        if (prewrite)
            for (int i = 0; i < 16; i++) step(1, 1, i, 2'b00, W'(18'h0AB00 + i * 37), 0, "R8");
        // latency and suspend
        step(1, 1, 3, 2'b11, '0, 0, lat);
        step(0, 1, 0, 2'b11, '0, 0, lat);
        step(0, 1, 0, 2'b11, '0, 0, "R7");
        step(0, 1, 0, 2'b11, '0, 0, "R7");
        step(1, 1, 5, 2'b11, '0, 0, lat);
        step(0, 1, 0, 2'b11, '0, 0, "R7");
        // write then immediate read of the same word
        step(1, 1, 7, 2'b00, W'(fl ? 18'h3C3C3 : 18'h12345), 0, "R9");
        step(1, 1, 7, 2'b11, '0, 0, "R9");
        step(0, 1, 0, 2'b11, '0, 0, "R9");
        // single-lane write
        step(1, 1, 9, 2'b10, W'(fl ? 18'h2A955 : 18'h155AA), 0, "R8");
        step(1, 1, 9, 2'b11, '0, 0, "R8");
        step(0, 1, 0, 2'b11, '0, 0, "R8");
        // deselect and ignored enables
        step(1, 1, 4, 2'b11, '0, 0, lat);
        step(1, 0, 4, 2'b11, '0, 0, "R6");
        step(0, 0, 4, 2'b00, W'(18'h3FFFF), 0, "R10");
        step(0, 0, 4, 2'b00, W'(18'h3FFFF), 0, "R10");
        step(1, 1, 4, 2'b11, '0, 0, "R10");
        step(0, 1, 0, 2'b11, '0, 0, "R10");
        // output enable gating, clocked and mid-cycle
        step(0, 1, 0, 2'b11, '0, 1, "R4");
        step(0, 1, 0, 2'b11, '0, 0, "R4");
        oe_n_i = 1'b1; #1;
        chk_bit(dq_oe_o, 1'b0, "R4");
        oe_n_i = 1'b0; #1;
        chk_bit(dq_oe_o, exp_oe(), "R4");
        // writes with output enable active
        step(1, 1, 2, 2'b00, W'(18'h0F0F0), 0, "R5");
        step(0, 1, 0, 2'b01, W'(18'h00333), 0, "R5");
        step(1, 1, 2, 2'b11, '0, 0, "R5");
        step(0, 1, 0, 2'b11, '0, 0, lat);
        // random traffic against the model
        for (int n = 0; n < 300; n++) begin
            bit ld, sel, oen;
            logic [NB-1:0] be;
            ld  = ($urandom_range(2) != 0);
            sel = ($urandom_range(5) != 0);
            oen = ($urandom_range(7) == 0);
            be  = ($urandom_range(2) == 0) ? NB'($urandom_range(3)) : '1;
            step(ld, sel, $urandom_range(15), be, W'($urandom), oen, lat);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; flow_sel_n = 1'b1; ld_i = 0; sel_i = 0; addr_i = '0;
        be_n_i = '1; wdata_i = '0; oe_n_i = 1'b0;
        for (int i = 0; i < 256; i++) mm[i] = '0;
        run_mode(1'b0, 1'b1);
        run_mode(1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule